// File: doc/BRIEF.md
# Four-Word Flash Block Write Buffer

This block sits between a processor's memory-access registers and a 14-bit-wide program flash array. A word address is built from a high address byte and a low address byte. Its two lowest bits choose one of four buffer slots. A write strobe whose address ends in 00, 01 or 10 only fills the matching slot and completes at once. A write strobe whose address ends in 11 fills the last slot and then commits all four slots to the aligned four-word block: the block is erased to all ones and then programmed. The processor is held by the stall output for the whole commit.

Word reads take a fixed two stall cycles, after which the read data is presented. A 2-bit protection level marks a region at the bottom of the array as write-protected, and writes into that region are dropped. The unlock sequence that gates the write strobe is detected elsewhere. This block only sees a strobe that has already been qualified. When each write finishes, a one-cycle completion pulse lets the status logic clear its busy bit and raise its interrupt flag.

Top module: `fbw_top`

## Requirements
- R1: The word address is the low 13 bits of {addr_hi, addr_lo}. The array holds 2^IDX_W words, and any address at or above that size wraps modulo the array size.
- R2: An unprotected write strobe, taken in idle, whose address low bits are 00, 01 or 10 loads that slot only. The next cycle shows wr_done high and stall low, and the array is not changed.
- R3: An unprotected write strobe, taken in idle, whose address low bits are 11 loads slot 3. Stall is then high for exactly 2 + COMMIT_CYCLES cycles. After that, the aligned block holds slots 0..3 at offsets 00..11.
- R4: A commit erases the block to all ones before programming, and programming can only clear bits. Slots keep their contents after a commit, so a commit that follows a write to slot 3 alone rewrites the other three words from the retained slots.
- R5: wr_done is high for one cycle in the first cycle after a commit in which stall is low.
- R6: A read strobe taken in idle holds stall high for two cycles. The next cycle shows rd_valid high for one cycle, with rdata holding the array word. rdata keeps that value until the next read completes.
- R7: Protection level 0 protects nothing, level 1 the lowest quarter of the array, level 2 the lowest half and level 3 all of it. A write into a protected word loads no slot and starts no commit. It still gives wr_done on the next cycle.
- R8: Write and read strobes that arrive while stall is high are ignored.
- R9: After reset, stall, rd_valid and wr_done are low, rdata is zero, and every array word and buffer slot is all ones.
- R10: When both strobes arrive in the same idle cycle, the write is taken and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_hi | input | 8 | High byte of the word address |
| addr_lo | input | 8 | Low byte of the word address |
| wdata | input | 14 | Word to be buffered |
| wr_go | input | 1 | Unlocked write strobe |
| rd_go | input | 1 | Read strobe |
| prot_lvl | input | 2 | Write-protection level |
| rdata | output | 14 | Last word read |
| rd_valid | output | 1 | One-cycle pulse when rdata has been updated |
| stall | output | 1 | Holds the processor during a read or a commit |
| wr_done | output | 1 | One-cycle pulse when a write has finished |

## Verification
The hardest case to reach is a commit whose slots mix values from different write sequences. Slots filled earlier at wrapped addresses must survive a protected write that was dropped and a write strobe sent in the middle of a stall. The only way to see this is that words later appear in a block that never received them directly. The stimulus fills the slots through wrapped high-byte addresses, tries protected and mid-stall writes to slot 0, and then commits new blocks through slot 3 alone. It reads back the neighbouring words to show that the retained slot values, not the dropped ones, reached the array. Rewriting slot 3 with a value that has more bits set than the old one shows that the erase takes place, because programming without an erase could only clear bits.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
    localparam int SLOT_CNT  = 4;
    localparam int SETUP_CYC = 2;
    localparam int READ_CYC  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_SETUP,
        ST_COMMIT
    } fbw_state_e;
endpackage

// File: rtl/fbw_guard.sv
module fbw_guard #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       level,
    output logic             blocked
);
    always_comb begin
        case (level)
            2'd0:    blocked = 1'b0;
            2'd1:    blocked = (idx[IDX_W-1:IDX_W-2] == 2'b00);
            2'd2:    blocked = (idx[IDX_W-1] == 1'b0);
            default: blocked = 1'b1;
        endcase
    end
endmodule

// File: rtl/fbw_array.sv
module fbw_array
    import fbw_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int DW    = 14
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          erase_en,
    input  logic                          prog_en,
    input  logic [IDX_W-3:0]              blk,
    input  logic [SLOT_CNT-1:0][DW-1:0]   prog_words,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [DW-1:0]                 rd_word
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (erase_en) begin
            for (int s = 0; s < SLOT_CNT; s++) mem[{blk, s[1:0]}] <= '1;
        end else if (prog_en) begin
            for (int s = 0; s < SLOT_CNT; s++)
                mem[{blk, s[1:0]}] <= mem[{blk, s[1:0]}] & prog_words[s];
        end
    end

    assign rd_word = mem[rd_idx];

    AST_ERASE_PROG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_en && prog_en)); // R4
    AST_PROG_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> !prog_en); // R4
endmodule

// File: rtl/fbw_top.sv
module fbw_top
    import fbw_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int IDX_W         = 8,
    parameter int DW            = 14,
    parameter int COMMIT_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    addr_hi,
    input  logic [7:0]    addr_lo,
    input  logic [DW-1:0] wdata,
    input  logic          wr_go,
    input  logic          rd_go,
    input  logic [1:0]    prot_lvl,
    output logic [DW-1:0] rdata,
    output logic          rd_valid,
    output logic          stall,
    output logic          wr_done
);
    localparam int CW = $clog2(COMMIT_CYCLES + SETUP_CYC + READ_CYC) + 1;

    typedef struct packed {
        fbw_state_e                  st;
        logic [CW-1:0]               cnt;
        logic [IDX_W-3:0]            blk;
        logic [IDX_W-1:0]            ridx;
        logic [SLOT_CNT-1:0][DW-1:0] slots;
        logic [DW-1:0]               rdata;
        logic                        rdv;
        logic                        done;
    } fbw_regs_t;

    fbw_regs_t q, d;

    logic [15:0]       addr_pair;
    logic [ADDR_W-1:0] addr_word;
    logic [IDX_W-1:0]  idx;
    logic [15-IDX_W:0] addr_unused;
    logic              blocked;
    logic              erase_en, prog_en;
    logic [DW-1:0]     rd_word;

    assign addr_pair   = {addr_hi, addr_lo};
    assign addr_word   = addr_pair[ADDR_W-1:0];
    assign idx         = addr_word[IDX_W-1:0];
    assign addr_unused = addr_pair[15:IDX_W];

    fbw_guard #(.IDX_W(IDX_W)) u_guard (
        .idx     (idx),
        .level   (prot_lvl),
        .blocked (blocked)
    );

    fbw_array #(.IDX_W(IDX_W), .DW(DW)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .erase_en   (erase_en),
        .prog_en    (prog_en),
        .blk        (q.blk),
        .prog_words (q.slots),
        .rd_idx     (q.ridx),
        .rd_word    (rd_word)
    );

    always_comb begin
        d        = q;
        d.rdv    = 1'b0;
        d.done   = 1'b0;
        erase_en = 1'b0;
        prog_en  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (wr_go) begin
                    if (blocked) begin
                        d.done = 1'b1;
                    end else begin
                        d.slots[idx[1:0]] = wdata;
                        if (idx[1:0] == 2'b11) begin
                            d.st  = ST_SETUP;
                            d.cnt = '0;
                            d.blk = idx[IDX_W-1:2];
                        end else begin
                            d.done = 1'b1;
                        end
                    end
                end else if (rd_go) begin
                    d.st   = ST_READ;
                    d.cnt  = '0;
                    d.ridx = idx;
                end
            end
            ST_READ: begin
                if (q.cnt == CW'(READ_CYC - 1)) begin
                    d.st    = ST_IDLE;
                    d.rdata = rd_word;
                    d.rdv   = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SETUP: begin
                if (q.cnt == CW'(SETUP_CYC - 1)) begin
                    erase_en = 1'b1;
                    d.st     = ST_COMMIT;
                    d.cnt    = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                if (q.cnt == CW'(COMMIT_CYCLES - 1)) begin
                    prog_en = 1'b1;
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.slots <= '1;
        end else begin
            q <= d;
        end
    end

    assign rdata    = q.rdata;
    assign rd_valid = q.rdv;
    assign stall    = (q.st != ST_IDLE);
    assign wr_done  = q.done;

    logic idle_wr;
    assign idle_wr = (q.st == ST_IDLE) && wr_go;

    AST_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_wr && !blocked && idx[1:0] != 2'b11) |=> (wr_done && !stall)); // R2
    AST_COMMIT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_wr && !blocked && idx[1:0] == 2'b11) |=> (stall && !wr_done)); // R3
    AST_COMMIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stall) && $past(q.st) == ST_COMMIT) |-> wr_done); // R5
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rdata)); // R6
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_done)); // R6
    AST_PROT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_wr && blocked) |=> (!stall && wr_done && $stable(q.slots))); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && (wr_go || rd_go)) |=> $stable(q.slots)); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_wr && rd_go) |=> (q.st != ST_READ)); // R10
endmodule

// File: tb/fbw_top_bench.sv
module fbw_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 8;
    localparam int DW         = 14;
    localparam int DEPTH      = 1 << IDX_W;
    localparam int COMMIT     = 64;
    localparam int WD_LIMIT   = 150000;
    localparam int ONES       = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    addr_hi = '0, addr_lo = '0;
    logic [DW-1:0] wdata = '0;
    logic          wr_go = 1'b0, rd_go = 1'b0;
    logic [1:0]    prot_lvl = '0;
    logic [DW-1:0] rdata;
    logic          rd_valid, stall, wr_done;

    fbw_top #(.IDX_W(IDX_W), .DW(DW), .COMMIT_CYCLES(COMMIT)) u_fbw_top (
        .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .addr_lo(addr_lo),
        .wdata(wdata), .wr_go(wr_go), .rd_go(rd_go), .prot_lvl(prot_lvl),
        .rdata(rdata), .rd_valid(rd_valid), .stall(stall), .wr_done(wr_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0, n_errors = 0, wd_cnt = 0;
    string tag = "R9";

    // behavioural reference state
    int m_mem [DEPTH];
    int m_buf [4];
    int m_left, m_ridx, m_base, m_rdata;
    bit m_commit, m_rdv, m_done;

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt == WD_LIMIT) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired (%s) actual=hung expected=finished", tag);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit prot_hit(int i, int lvl);
        case (lvl)
            0: return 0;
            1: return i < DEPTH/4;
            2: return i < DEPTH/2;
            default: return 1;
        endcase
    endfunction

    task automatic model_init();
        for (int i = 0; i < DEPTH; i++) m_mem[i] = ONES;
        for (int s = 0; s < 4; s++) m_buf[s] = ONES;
        m_left = 0; m_rdata = 0; m_rdv = 0; m_done = 0; m_commit = 0;
    endtask

    task automatic model_step();
        int i;
        i = ((int'(addr_hi) << 8) | int'(addr_lo)) % 8192 % DEPTH;
        m_rdv = 0; m_done = 0;
        if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
                if (m_commit) begin
                    for (int s = 0; s < 4; s++) m_mem[m_base + s] = m_buf[s];
                    m_done = 1;
                end else begin
                    m_rdata = m_mem[m_ridx];
                    m_rdv = 1;
                end
            end
        end else if (wr_go) begin
            if (prot_hit(i, int'(prot_lvl))) m_done = 1;
            else begin
                m_buf[i % 4] = int'(wdata);
                if (i % 4 == 3) begin
                    m_left = 2 + COMMIT; m_commit = 1; m_base = i - 3;
                end else m_done = 1;
            end
        end else if (rd_go) begin
            m_left = 2; m_commit = 0; m_ridx = i;
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        chk(tag, "stall", int'(stall), int'(m_left > 0));
        chk(tag, "rd_valid", int'(rd_valid), int'(m_rdv));
        chk(tag, "wr_done", int'(wr_done), int'(m_done));
        chk(tag, "rdata", int'(rdata), m_rdata);
    endtask

    task automatic set_addr(int a);
        addr_hi = 8'(a >> 8);
        addr_lo = 8'(a);
    endtask

    task automatic do_write(int a, int v);
        set_addr(a); wdata = DW'(v); wr_go = 1'b1;
        tick();
        wr_go = 1'b0;
        while (stall) tick();
    endtask

    task automatic do_read(int a, int exp, string req);
        set_addr(a); rd_go = 1'b1;
        tick();
        rd_go = 1'b0;
        tick(); tick();
        chk(req, "read data", int'(rdata), exp);
        chk(req, "read valid", int'(rd_valid), 1);
    endtask

    initial begin
        int n;
        model_init();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9 reset state
        chk("R9", "stall", int'(stall), 0);
        chk("R9", "rd_valid", int'(rd_valid), 0);
        chk("R9", "wr_done", int'(wr_done), 0);
        chk("R9", "rdata", int'(rdata), 0);
        do_read(5, ONES, "R9");

        // R6 read stall length and hold
        tag = "R6";
        set_addr(6); rd_go = 1'b1; tick(); rd_go = 1'b0;
        chk("R6", "stall cycle 1", int'(stall), 1);
        tick();
        chk("R6", "stall cycle 2", int'(stall), 1);
        tick();
        chk("R6", "stall released", int'(stall), 0);

        // R2 slot loads only
        tag = "R2";
        for (int k = 0; k < 3; k++) begin
            set_addr(8 + k); wdata = DW'(32'h111 * (k + 1)); wr_go = 1'b1;
            tick(); wr_go = 1'b0;
            chk("R2", "no stall on slot load", int'(stall), 0);
            chk("R2", "done on slot load", int'(wr_done), 1);
        end
        do_read(8, ONES, "R2");
        tick();
        chk("R6", "rdata held", int'(rdata), ONES);

        // R3 / R5 commit timing and contents
        tag = "R3";
        set_addr(11); wdata = 14'h0444; wr_go = 1'b1; tick(); wr_go = 1'b0;
        n = 0;
        while (stall) begin n++; tick(); end
        chk("R3", "stall length", n, COMMIT + 2);
        chk("R5", "done after commit", int'(wr_done), 1);
        tick();
        chk("R5", "done is one cycle", int'(wr_done), 0);
        do_read(8,  14'h0111, "R3");
        do_read(10, 14'h0333, "R3");
        do_read(11, 14'h0444, "R3");

        // R4 retained slots, erase before program
        tag = "R4";
        do_write(11, 14'h0555);
        do_read(11, 14'h0555, "R4");
        do_read(9,  14'h0222, "R4");

        // R1 address wrap
        tag = "R1";
        for (int k = 0; k < 4; k++) do_write(16'hE10C + k, 14'h1001 + k);
        do_read(12, 14'h1001, "R1");
        do_read(15, 14'h1004, "R1");
        do_read(16'h1F0D, 14'h1002, "R1");

        // R7 protection levels
        tag = "R7";
        prot_lvl = 2'd1;
        do_write(16'h10, 14'h0BAD);
        set_addr(16'h13); wdata = 14'h0AAA; wr_go = 1'b1; tick(); wr_go = 1'b0;
        chk("R7", "protected no stall", int'(stall), 0);
        chk("R7", "protected done", int'(wr_done), 1);
        do_read(16'h13, ONES, "R7");
        do_write(16'h43, 14'h2222);
        do_read(16'h43, 14'h2222, "R7");
        do_read(16'h40, 14'h1001, "R7");
        prot_lvl = 2'd2;
        do_write(16'h7F, 14'h0123);
        do_read(16'h7F, ONES, "R7");
        do_write(16'h83, 14'h0321);
        do_read(16'h83, 14'h0321, "R7");
        prot_lvl = 2'd3;
        do_write(16'hC3, 14'h0101);
        do_read(16'hC3, ONES, "R7");
        prot_lvl = 2'd0;
        do_write(16'h13, 14'h0777);
        do_read(16'h10, 14'h1001, "R7");

        // R8 strobes during stall
        tag = "R8";
        set_addr(16'h23); wdata = 14'h0999; wr_go = 1'b1; tick(); wr_go = 1'b0;
        tick();
        set_addr(16'h30); wdata = 14'h0123; wr_go = 1'b1; rd_go = 1'b1; tick();
        wr_go = 1'b0; rd_go = 1'b0;
        tick();
        set_addr(16'h33); wr_go = 1'b1; tick(); wr_go = 1'b0;
        while (stall) tick();
        do_read(16'h23, 14'h0999, "R8");
        do_read(16'h33, ONES, "R8");
        do_write(16'h37, 14'h0456);
        do_read(16'h34, 14'h1001, "R8");

        // R10 simultaneous strobes
        tag = "R10";
        set_addr(16'h50); wdata = 14'h0321; wr_go = 1'b1; rd_go = 1'b1; tick();
        wr_go = 1'b0; rd_go = 1'b0;
        chk("R10", "read dropped", int'(stall), 0);
        chk("R10", "write taken", int'(wr_done), 1);
        tick();
        chk("R10", "no read data", int'(rd_valid), 0);
        do_write(16'h53, 14'h0654);
        do_read(16'h50, 14'h0321, "R10");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule